// File: doc/BRIEF.md
# Shared Soft-Start Ramp Arbiter

This block lets two power channels share one soft-start reference ramp. The ramp is a digital code counter that feeds a single DAC. It climbs from zero to full scale in a fixed number of clock cycles. Each channel raises an enable request, which has already been compared against its turn-on threshold. A request that arrives while the ramp serves the other channel waits for that ramp to finish. Two requests that come close together share one joint ramp.

A channel whose ramp has completed holds its reference at full scale until its request drops. Dropping a request always returns that channel to idle at once. This applies whether the channel is waiting, ramping or done. A global standby enable gates both requests, so no channel ramps or stays done while standby is off.

The ramp time is `2**CODE_W * STEP_CYCLES` clock cycles. The coalescing window is `MERGE_CYCLES` cycles. Choose both from the clock frequency to get the wanted soft-start time, for example 1.6 ms, and merge window, for example 60 µs.

Top module: `ss_ramp_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `ss_active`, `ss_done`, `ch_ref` and `dac_code` are all zero.
- R2: A channel requests when `stby_en` and its `ch_en` bit are both high. A lone request, made while the ramp is free and the other channel is idle, opens a merge window. Its `ss_active` bit rises on the edge that comes `MERGE_CYCLES+1` clock edges after the edge that first samples the request.
- R3: The ramp code starts at zero on the edge where `ss_active` rises. It increases by one every `STEP_CYCLES` edges, so it equals floor(k/`STEP_CYCLES`) after k edges. While a channel is active, its `ch_ref` slice equals that code. Exactly `2**CODE_W*STEP_CYCLES` edges after the rise, `ss_active` clears and `ss_done` sets. The slice then holds all ones.
- R4: A second request may be sampled no later than `MERGE_CYCLES` edges after the first request's sampling edge, or on the same edge. In that case both `ss_active` bits rise together one edge after the later sampling edge, and the two `ch_ref` slices stay equal.
- R5: A request sampled while the other channel is ramping, including `MERGE_CYCLES+1` edges after a window opened, is deferred. Its `ss_active` rises one edge after the edge on which the other channel's `ss_done` rises, never while the other channel is active.
- R6: A request made while the other channel is done starts with no merge window. Its `ss_active` rises one edge after the sampling edge.
- R7: Dropping a channel's request during its ramp clears its `ss_active` and its `ch_ref` slice on the next edge. The other channel, if it is still ramping, continues with an unchanged code sequence.
- R8: A request withdrawn before its ramp starts is discarded. The channel never becomes active from it.
- R9: Dropping the request of a done channel clears its `ss_done` and its `ch_ref` slice on the next edge.
- R10: While `stby_en` is low, both channels are forced idle on the next edge and `ch_en` is ignored.
- R11: While at least one channel stays active across consecutive cycles, `dac_code` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stby_en | input | 1 | Standby master enable; gates both requests |
| ch_en | input | 2 | Per-channel enable request, bit 0 = channel 0, bit 1 = channel 1 |
| dac_code | output | CODE_W | Shared ramp code driven to the DAC; zero while the ramp is free |
| ch_ref | output | 2*CODE_W | Per-channel reference code, channel 0 in bits [CODE_W-1:0], channel 1 in the upper slice |
| ss_active | output | 2 | Per-channel soft-start in progress |
| ss_done | output | 2 | Per-channel soft-start complete, reference at full scale |

## Verification
The scheduling is tried with several input patterns. A lone request with the partner idle checks the full merge-window wait. A request made while the partner is done must start at once. Requests on the same edge, and a second request inside the window, must merge into one ramp. A second request on the last window edge must still merge, while one edge later it must be deferred behind a full ramp. Aborts during a shared ramp, withdrawal of a pending request, release of a done channel, standby off and reset in mid-ramp show that each teardown path clears only what it should.

// File: rtl/ssarb_pkg.sv
// Package: shared types for the soft-start ramp arbiter.
// Assumes exactly two channels share one ramp engine.
package ssarb_pkg;

    localparam int NCH = 2;

    // Per-channel soft-start progress.
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_RAMP = 2'd2,
        CH_DONE = 2'd3
    } ch_state_e;

    // Shared ramp engine occupancy.
    typedef enum logic [1:0] {
        ENG_FREE  = 2'd0,
        ENG_MERGE = 2'd1,
        ENG_BUSY  = 2'd2
    } eng_state_e;

endpackage

// File: rtl/ssarb_chan.sv
// Module: one channel's soft-start tracker.
// Moves the channel through idle, waiting, ramping and done.
// Any drop of the qualified request sends it back to idle.
// Assumes start is only pulsed while the channel waits.
// Assumes finish is only pulsed while it ramps.
module ssarb_chan
    import ssarb_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              start,
    input  logic              finish,
    input  logic [CODE_W-1:0] code,
    output logic              pending,
    output logic              active,
    output logic              done,
    output logic [CODE_W-1:0] ref_code
);

    localparam logic [CODE_W-1:0] FULL = '1;

    ch_state_e st_q, st_d;

    // Next channel state from request, start and finish strobes.
    always_comb begin
        st_d = st_q;
        if (!req) begin
            st_d = CH_IDLE;
        end else begin
            unique case (st_q)
                CH_IDLE: st_d = CH_WAIT;
                CH_WAIT: if (start)  st_d = CH_RAMP;
                CH_RAMP: if (finish) st_d = CH_DONE;
                CH_DONE: st_d = CH_DONE;
                default: st_d = CH_IDLE;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    assign pending = (st_q == CH_WAIT);
    assign active  = (st_q == CH_RAMP);
    assign done    = (st_q == CH_DONE);

    // Reference: follows the ramp, holds full scale when done, else zero.
    always_comb begin
        if (active)    ref_code = code;
        else if (done) ref_code = FULL;
        else           ref_code = '0;
    end

endmodule

// File: rtl/ssarb_ramp.sv
// Module: shared ramp code generator.
// Advances the code by one every STEP_CYCLES cycles while run is high.
// The code stops at full scale.
// at_end flags the last cycle of the full-scale step.
// Assumes clr and run are never high together.
module ssarb_ramp #(
    parameter int CODE_W      = 6,
    parameter int STEP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    output logic [CODE_W-1:0] code,
    output logic              at_end
);

    localparam int SW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [SW-1:0]     STEP_LAST = SW'(STEP_CYCLES - 1);
    localparam logic [CODE_W-1:0] FULL      = '1;

    logic [SW-1:0]     scnt_q;
    logic [CODE_W-1:0] code_q;
    logic              step_last;

    assign step_last = (scnt_q == STEP_LAST);
    assign at_end    = run && step_last && (code_q == FULL);
    assign code      = code_q;

    // Step prescaler and code counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            scnt_q <= '0;
            code_q <= '0;
        end else if (run) begin
            if (step_last) begin
                scnt_q <= '0;
                if (code_q != FULL) code_q <= code_q + 1'b1;
            end else begin
                scnt_q <= scnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ssarb_sched.sv
// Module: ramp scheduler.
// Decides when the shared ramp starts and which channels join it.
// A lone request opens a merge window of MERGE_CYCLES cycles, unless the
// partner channel is already done.
// A second request inside the window starts a joint ramp at once.
// Requests seen while the ramp is busy stay pending until it is free.
// Assumes MERGE_CYCLES >= 1.
module ssarb_sched
    import ssarb_pkg::*;
#(
    parameter int MERGE_CYCLES = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] pending,
    input  logic [NCH-1:0] active,
    input  logic [NCH-1:0] done,
    input  logic           at_end,
    output logic [NCH-1:0] start,
    output logic [NCH-1:0] finish,
    output logic           ramp_run,
    output logic           ramp_clr
);

    localparam int WW = $clog2(MERGE_CYCLES + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(MERGE_CYCLES - 1);

    eng_state_e    eng_q, eng_d;
    logic          first_q, first_d;
    logic [WW-1:0] wcnt_q, wcnt_d;
    logic [NCH-1:0] pend, live;
    logic           solo;

    assign pend = pending & req;
    assign live = active & req;
    assign solo = pend[1];

    // Scheduling decision for the current cycle.
    always_comb begin
        eng_d   = eng_q;
        first_d = first_q;
        wcnt_d  = wcnt_q;
        start   = '0;
        finish  = '0;
        unique case (eng_q)
            ENG_FREE: begin
                if (pend == 2'b11) begin
                    start = 2'b11;
                    eng_d = ENG_BUSY;
                end else if (pend != 2'b00) begin
                    if (done[!solo]) begin
                        start[solo] = 1'b1;
                        eng_d       = ENG_BUSY;
                    end else begin
                        eng_d   = ENG_MERGE;
                        first_d = solo;
                        wcnt_d  = '0;
                    end
                end
            end
            ENG_MERGE: begin
                if (pend == 2'b11) begin
                    start = 2'b11;
                    eng_d = ENG_BUSY;
                end else if (!pend[first_q]) begin
                    eng_d = ENG_FREE;
                end else if (wcnt_q == WIN_LAST) begin
                    start[first_q] = 1'b1;
                    eng_d          = ENG_BUSY;
                end else begin
                    wcnt_d = wcnt_q + 1'b1;
                end
            end
            ENG_BUSY: begin
                if (live == 2'b00) begin
                    eng_d = ENG_FREE;
                end else if (at_end) begin
                    finish = live;
                    eng_d  = ENG_FREE;
                end
            end
            default: eng_d = ENG_FREE;
        endcase
    end

    // Scheduler registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q   <= ENG_FREE;
            first_q <= 1'b0;
            wcnt_q  <= '0;
        end else begin
            eng_q   <= eng_d;
            first_q <= first_d;
            wcnt_q  <= wcnt_d;
        end
    end

    assign ramp_run = (eng_q == ENG_BUSY) && (live != 2'b00);
    assign ramp_clr = (eng_q != ENG_BUSY);

endmodule

// File: rtl/ss_ramp_arbiter.sv
// Module: top of the shared soft-start ramp arbiter.
// Two channel trackers, one ramp scheduler and one ramp code generator.
// Ramp time is 2**CODE_W * STEP_CYCLES clock cycles.
// Assumes ch_en is already synchronous to clk and past its threshold.
module ss_ramp_arbiter
    import ssarb_pkg::*;
#(
    parameter int CODE_W       = 6,
    parameter int STEP_CYCLES  = 4,
    parameter int MERGE_CYCLES = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stby_en,
    input  logic [1:0]            ch_en,
    output logic [CODE_W-1:0]     dac_code,
    output logic [2*CODE_W-1:0]   ch_ref,
    output logic [1:0]            ss_active,
    output logic [1:0]            ss_done
);

    logic [NCH-1:0]    req, pending, start, finish;
    logic              ramp_run, ramp_clr, at_end;
    logic [CODE_W-1:0] code;

    assign req      = {NCH{stby_en}} & ch_en;
    assign dac_code = code;

    // One tracker per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ssarb_chan #(.CODE_W(CODE_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req[g]),
            .start    (start[g]),
            .finish   (finish[g]),
            .code     (code),
            .pending  (pending[g]),
            .active   (ss_active[g]),
            .done     (ss_done[g]),
            .ref_code (ch_ref[g*CODE_W +: CODE_W])
        );
    end

    ssarb_sched #(.MERGE_CYCLES(MERGE_CYCLES)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .pending  (pending),
        .active   (ss_active),
        .done     (ss_done),
        .at_end   (at_end),
        .start    (start),
        .finish   (finish),
        .ramp_run (ramp_run),
        .ramp_clr (ramp_clr)
    );

    ssarb_ramp #(.CODE_W(CODE_W), .STEP_CYCLES(STEP_CYCLES)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ramp_clr),
        .run    (ramp_run),
        .code   (code),
        .at_end (at_end)
    );

endmodule

// File: rtl/ssarb_checker.sv
// Module: property checker for ss_ramp_arbiter, attached by bind.
// Watches only the ports of the top module.
module ssarb_checker #(
    parameter int CODE_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stby_en,
    input logic [1:0]          ch_en,
    input logic [CODE_W-1:0]   dac_code,
    input logic [2*CODE_W-1:0] ch_ref,
    input logic [1:0]          ss_active,
    input logic [1:0]          ss_done
);

    localparam logic [CODE_W-1:0] FULL = '1;

    logic [CODE_W-1:0] ref0, ref1;
    assign ref0 = ch_ref[CODE_W-1:0];
    assign ref1 = ch_ref[2*CODE_W-1:CODE_W];

    AST_DONE_FULL_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done[0] |-> ref0 == FULL); // R3
    AST_DONE_FULL_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done[1] |-> ref1 == FULL); // R3
    AST_RAMP_FROM_ZERO_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_active[0]) |-> ref0 == '0); // R3
    AST_REF_TRACKS_DAC_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active[1] |-> ref1 == dac_code); // R3
    AST_JOINT_SAME_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active == 2'b11 |-> ref0 == ref1); // R4
    AST_NO_START_BEHIND_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_active[0]) |-> !$past(ss_active[1])); // R5
    AST_NO_START_BEHIND_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_active[1]) |-> !$past(ss_active[0])); // R5
    AST_DROP_RELEASES_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en[0] |=> !ss_active[0] && !ss_done[0]); // R9
    AST_DROP_RELEASES_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en[1] |=> !ss_active[1] && !ss_done[1]); // R7
    AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_en |=> ss_active == 2'b00 && ss_done == 2'b00); // R10
    AST_CODE_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_active != 2'b00 && $past(ss_active) != 2'b00) |-> dac_code >= $past(dac_code)); // R11

endmodule

bind ss_ramp_arbiter ssarb_checker #(.CODE_W(CODE_W)) u_ssarb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby_en   (stby_en),
    .ch_en     (ch_en),
    .dac_code  (dac_code),
    .ch_ref    (ch_ref),
    .ss_active (ss_active),
    .ss_done   (ss_done)
);

// File: tb/tb_ss_ramp_arbiter.sv
`timescale 1ns/1ps
module tb_ss_ramp_arbiter;

    localparam int CODE_W = 6;
    localparam int STEP   = 4;
    localparam int MERGE  = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                stby_en = 1'b0;
    logic [1:0]          ch_en = 2'b00;
    logic [CODE_W-1:0]   dac_code;
    logic [2*CODE_W-1:0] ch_ref;
    logic [1:0]          ss_active, ss_done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ss_ramp_arbiter #(.CODE_W(CODE_W), .STEP_CYCLES(STEP), .MERGE_CYCLES(MERGE)) dut (
        .clk(clk), .rst_n(rst_n), .stby_en(stby_en), .ch_en(ch_en),
        .dac_code(dac_code), .ch_ref(ch_ref), .ss_active(ss_active), .ss_done(ss_done)
    );

    // Each row: drive inputs, let n edges pass, then compare at the next falling edge.
    typedef struct packed {
        logic       stby;
        logic [1:0] en;
        logic [9:0] n;
        logic [1:0] act;
        logic [1:0] dn;
        logic [5:0] r0;
        logic [5:0] r1;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        '{1, 2'b00,   2, 2'b00, 2'b00,  0,  0,  1}, // R1 idle after reset
        '{1, 2'b01,   1, 2'b00, 2'b00,  0,  0,  2}, // R2 request sampled
        '{1, 2'b01,  12, 2'b00, 2'b00,  0,  0,  2}, // R2 still in window
        '{1, 2'b01,   1, 2'b01, 2'b00,  0,  0,  2}, // R2 starts MERGE+1 edges later
        '{1, 2'b01,  40, 2'b01, 2'b00, 10,  0,  3}, // R3 code = k/STEP
        '{1, 2'b01, 215, 2'b01, 2'b00, 63,  0,  3}, // R3 at full scale, not done
        '{1, 2'b01,   1, 2'b00, 2'b01, 63,  0,  3}, // R3 done after 256 edges
        '{1, 2'b11,   1, 2'b00, 2'b01, 63,  0,  6}, // R6 sampled
        '{1, 2'b11,   1, 2'b10, 2'b01, 63,  0,  6}, // R6 immediate start
        '{1, 2'b01,   1, 2'b00, 2'b01, 63,  0,  7}, // R7 abort ch1
        '{1, 2'b00,   1, 2'b00, 2'b00,  0,  0,  9}, // R9 release done
        '{1, 2'b11,   1, 2'b00, 2'b00,  0,  0,  4}, // R4 same-edge requests
        '{1, 2'b11,   1, 2'b11, 2'b00,  0,  0,  4}, // R4 joint start
        '{1, 2'b11, 255, 2'b11, 2'b00, 63, 63,  4}, // R4 shared code
        '{1, 2'b11,   1, 2'b00, 2'b11, 63, 63,  3}, // R3 both done
        '{0, 2'b11,   1, 2'b00, 2'b00,  0,  0, 10}, // R10 standby off
        '{0, 2'b11,  20, 2'b00, 2'b00,  0,  0, 10}, // R10 enables ignored
        '{1, 2'b10,   5, 2'b00, 2'b00,  0,  0,  2}, // R2 window open for ch1
        '{1, 2'b11,   1, 2'b00, 2'b00,  0,  0,  4}, // R4 second request in window
        '{1, 2'b11,   1, 2'b11, 2'b00,  0,  0,  4}, // R4 merged at once
        '{1, 2'b10,   1, 2'b10, 2'b00,  0,  0,  7}, // R7 ch0 aborts, ch1 goes on
        '{1, 2'b10,   8, 2'b10, 2'b00,  0,  2,  7}, // R7 ch1 code unchanged
        '{1, 2'b00,   1, 2'b00, 2'b00,  0,  0,  7}, // R7 both dropped
        '{1, 2'b01,   5, 2'b00, 2'b00,  0,  0,  8}, // R8 pending in window
        '{1, 2'b00,   1, 2'b00, 2'b00,  0,  0,  8}, // R8 withdrawn
        '{1, 2'b00,  20, 2'b00, 2'b00,  0,  0,  8}, // R8 never starts
        '{1, 2'b01,  14, 2'b01, 2'b00,  0,  0,  2}, // R2 fresh full window
        '{1, 2'b11,   1, 2'b01, 2'b00,  0,  0,  5}, // R5 ch1 deferred
        '{1, 2'b11,  40, 2'b01, 2'b00, 10,  0,  5}, // R5 still deferred
        '{1, 2'b11, 214, 2'b01, 2'b00, 63,  0,  5}, // R5 still deferred
        '{1, 2'b11,   1, 2'b00, 2'b01, 63,  0,  5}, // R5 ch0 done, ch1 waits
        '{1, 2'b11,   1, 2'b10, 2'b01, 63,  0,  5}, // R5 ch1 starts next edge
        '{1, 2'b00,   1, 2'b00, 2'b00,  0,  0,  9}, // R9 all released
        '{1, 2'b10,  12, 2'b00, 2'b00,  0,  0,  2}, // R2 window edges 1..12
        '{1, 2'b11,   1, 2'b00, 2'b00,  0,  0,  4}, // R4 second at last window edge
        '{1, 2'b11,   1, 2'b11, 2'b00,  0,  0,  4}, // R4 still merged
        '{1, 2'b00,   1, 2'b00, 2'b00,  0,  0,  7}, // R7 abort both
        '{1, 2'b00,   2, 2'b00, 2'b00,  0,  0,  7}, // R7 stays idle
        '{1, 2'b10,  13, 2'b00, 2'b00,  0,  0,  2}, // R2 window edges 1..13
        '{1, 2'b11,   1, 2'b10, 2'b00,  0,  0,  5}, // R5 one edge late: ch1 alone
        '{1, 2'b11,   1, 2'b10, 2'b00,  0,  0,  5}, // R5 ch0 deferred
        '{1, 2'b00,   1, 2'b00, 2'b00,  0,  0,  9}  // R9 release
    };

    function automatic string tag_s(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic compare(input string rq, input logic [1:0] act, input logic [1:0] dn,
                           input logic [5:0] r0, input logic [5:0] r1, input int row);
        vectors++;
        if (ss_active !== act || ss_done !== dn ||
            ch_ref[CODE_W-1:0] !== r0 || ch_ref[2*CODE_W-1:CODE_W] !== r1) begin
            miscompares++;
            $display("FAIL %s row %0d: actual act=%b done=%b ref0=%0d ref1=%0d expected act=%b done=%b ref0=%0d ref1=%0d",
                     rq, row, ss_active, ss_done, ch_ref[CODE_W-1:0], ch_ref[2*CODE_W-1:CODE_W],
                     act, dn, r0, r1);
        end
    endtask

    task automatic check_zero(input string rq);
        vectors++;
        if (ss_active !== 2'b00 || ss_done !== 2'b00 || ch_ref !== '0 || dac_code !== '0) begin
            miscompares++;
            $display("FAIL %s reset: actual act=%b done=%b ref=%h dac=%0d expected all zero",
                     rq, ss_active, ss_done, ch_ref, dac_code);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: outputs zero under reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_zero("R1");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_zero("R1");

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            stby_en = VECS[i].stby;
            ch_en   = VECS[i].en;
            for (int c = 0; c < int'(VECS[i].n); c++) @(posedge clk);
            @(negedge clk);
            compare(tag_s(VECS[i].tag), VECS[i].act, VECS[i].dn, VECS[i].r0, VECS[i].r1, i);
        end

        // R1: reset in the middle of a ramp clears everything.
        ch_en = 2'b01;
        repeat (30) @(posedge clk);
        @(negedge clk);
        compare("R1", 2'b01, 2'b00, 6'd4, 6'd0, 100);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_zero("R1");
        ch_en = 2'b00;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_zero("R1");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule